// File: doc/BRIEF.md
# Reset and vector fetch sequencer

This block takes a small 24-bit-address processor out of reset. An active-low external reset pin is sampled on every system clock. A low level counts as a reset only after it has been seen for a minimum number of consecutive clocks, so glitches and short pulses are ignored. The block also takes a power-good indication (`porN`), which is low until the supply and the oscillator are stable. While reset is active, the block does the following:

- It holds every peripheral register in reset through a strobe.
- It tri-states the address-latch-enable pad.
- It returns the clock gear to its slowest default. At that setting the system clock is the oscillator divided by 32.
- It loads the stack pointer and the status-register fields with their start values.

When the pin is released, the block reads three start-address bytes from fixed ascending addresses over a byte-wide read port. Each read waits for a ready handshake. The bytes are packed into the program counter, least significant byte first. One clock after the top byte is stored, a run signal tells the core to start fetching. A new qualified reset in any phase abandons the sequence at once.

The program counter is only ever written by the vector capture. The block has no write path to the RAM or to any other processor register, so those keep their contents through a reset.

Top module: `boot_seq`

## Requirements
- R1: `periphRstN` falls on the rising edge that samples `rstInN` low for the tenth consecutive time (MIN_LOW = 10), and stays low while `rstInN` stays low.
- R2: A low pulse on `rstInN` lasting fewer than MIN_LOW sampled clocks has no effect on any output. A single high sample restarts the count from zero.
- R3: While reset is active, including while `porN` is low, `periphRstN`, `aleOe` (0 means the pad is tri-stated), `run` and `memRdReq` are all 0.
- R4: While reset is active, the following values are loaded:
  - `sp` becomes 24'h000100.
  - `srIntMask` becomes 3'b111.
  - `srMaxMode` becomes 1.
  - `srBank` becomes 3'b000.
- R5: While reset is active, `gearSel` is forced to 3'd4. This code is the divide-by-16 gear, which gives a system clock of the oscillator divided by 32.
- R6: On the first clock in which `rstInN` is sampled high during reset, the block issues reads at `memAddr` 24'hFFFF00, then 24'hFFFF01, then 24'hFFFF02. `memRdReq` is 1 during each read, and the address holds until `memRdy` is sampled 1. When no read is pending, `memAddr` is 0.
- R7: The byte on `memRdData` is stored when `memRdy` is sampled 1. The byte from offset k goes to `pc[8k+7:8k]`.
- R8: `run` rises exactly one clock after the edge that stores the third byte, and then stays 1 until the next reset.
- R9: A reset that becomes qualified during the fetch aborts the sequence back to reset. A byte whose `memRdy` arrives on that same edge is not stored.
- R10: `gearWe` loads `gearReq` into `gearSel` only while `run` is 1. A qualifying reset on the same edge takes priority, and any write during reset is ignored.
- R11: `pc` keeps its value through reset and changes only on a vector byte capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Power-good and oscillator-stable, low forces reset asynchronously |
| rstInN | input | 1 | External reset pin, active low, unfiltered |
| memRdReq | output | 1 | Vector byte read request |
| memAddr | output | 24 | Vector byte address |
| memRdData | input | 8 | Read data byte |
| memRdy | input | 1 | Read data valid this cycle |
| gearWe | input | 1 | Core request to change the clock gear |
| gearReq | input | 3 | Requested gear code |
| gearSel | output | 3 | Current clock gear code |
| pc | output | 24 | Start program counter |
| sp | output | 24 | Stack pointer start value |
| srIntMask | output | 3 | Status register interrupt mask level |
| srMaxMode | output | 1 | Status register maximum-mode bit |
| srBank | output | 3 | Status register register-bank select |
| periphRstN | output | 1 | Reset strobe to peripheral registers, active low |
| aleOe | output | 1 | Address-latch-enable pad drive enable |
| run | output | 1 | Core may begin instruction fetch |

## Verification
Two events can fall on the same edge: the reset filter reaching its threshold, and a vector read completing or a gear write landing. To provoke the first case, the bench holds `rstInN` low from the start of the second vector read. Its memory model withholds `memRdy` until the cycle in which the tenth low sample is taken. The result is judged by seeing `pc` keep its previous middle byte while the outputs drop into reset. For the second case, a gear write is held asserted across the moment of qualification, and `gearSel` must end at the default code. A behavioural model in the bench predicts every output on every clock, so the exact edge on which each event wins is compared, and not just the final state.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [1:0] {
    BS_HOLD   = 2'd0,
    BS_FETCH  = 2'd1,
    BS_LAUNCH = 2'd2,
    BS_RUN    = 2'd3
  } bootPhase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       initLoad;  // reset values into SP, SR and gear
    logic       byteCap;   // store the vector byte on memRdData
    logic [1:0] byteSel;   // which PC lane / vector offset
    logic       gearWr;    // accept a gear change from the core
  } bootStrobe_t;

endpackage

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
#(
  parameter int MIN_LOW   = 10,
  parameter int VEC_BYTES = 3
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        rstInN,
  input  logic        memRdy,
  input  logic        gearWe,
  output bootStrobe_t strobe,
  output logic        fetching,
  output logic        periphRstN,
  output logic        aleOe,
  output logic        run
);

  localparam int CNT_W = $clog2(MIN_LOW + 1);

  logic [CNT_W-1:0] lowCnt;
  logic [1:0]       idx;
  logic             qualified;
  bootPhase_e       phase, phaseNxt;

  // R1/R2: low-time filter, saturating, cleared by any high sample
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                          lowCnt <= '0;
    else if (rstInN)                    lowCnt <= '0;
    else if (lowCnt != CNT_W'(MIN_LOW)) lowCnt <= lowCnt + 1'b1;
  end

  // true on the edge that takes the MIN_LOW-th consecutive low sample
  assign qualified = !rstInN && (lowCnt >= CNT_W'(MIN_LOW - 1));

  always_comb begin
    phaseNxt = phase;
    if (qualified) begin
      phaseNxt = BS_HOLD;                              // R9 abort from any phase
    end else begin
      unique case (phase)
        BS_HOLD:   if (rstInN) phaseNxt = BS_FETCH;
        BS_FETCH:  if (memRdy && idx == 2'(VEC_BYTES - 1)) phaseNxt = BS_LAUNCH;
        BS_LAUNCH: phaseNxt = BS_RUN;                  // R8 one-clock gap
        BS_RUN:    phaseNxt = BS_RUN;
        default:   phaseNxt = BS_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) phase <= BS_HOLD;
    else       phase <= phaseNxt;
  end

  // R6: byte offset, restarts at zero whenever not fetching
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                  idx <= '0;
    else if (phase != BS_FETCH) idx <= '0;
    else if (strobe.byteCap)    idx <= idx + 1'b1;
  end

  always_comb begin
    strobe.initLoad = (phase == BS_HOLD);
    strobe.byteCap  = (phase == BS_FETCH) && memRdy && !qualified;
    strobe.byteSel  = idx;
    strobe.gearWr   = (phase == BS_RUN) && gearWe && !qualified;
  end

  assign fetching   = (phase == BS_FETCH);
  assign periphRstN = (phase != BS_HOLD);
  assign aleOe      = (phase != BS_HOLD);
  assign run        = (phase == BS_RUN);

endmodule

// File: rtl/boot_seq_dp.sv
module boot_seq_dp
  import boot_seq_pkg::*;
#(
  parameter int              ADDR_W    = 24,
  parameter int              BYTE_W    = 8,
  parameter int              GEAR_W    = 3,
  parameter int              MASK_W    = 3,
  parameter int              BANK_W    = 3,
  parameter logic [ADDR_W-1:0] VEC_BASE  = 24'hFFFF00,
  parameter logic [ADDR_W-1:0] SP_INIT   = 24'h000100,
  parameter logic [GEAR_W-1:0] GEAR_INIT = 3'd4
) (
  input  logic              clk,
  input  logic              porN,
  input  bootStrobe_t       strobe,
  input  logic              fetching,
  input  logic [BYTE_W-1:0] memRdData,
  input  logic [GEAR_W-1:0] gearReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic [MASK_W-1:0] srIntMask,
  output logic              srMaxMode,
  output logic [BANK_W-1:0] srBank,
  output logic [GEAR_W-1:0] gearSel
);

  localparam int VEC_BYTES = ADDR_W / BYTE_W;

  // R7/R11: one lane per vector byte, written only by a capture strobe
  for (genvar g = 0; g < VEC_BYTES; g++) begin : g_lane
    always_ff @(posedge clk or negedge porN) begin
      if (!porN)
        pc[g*BYTE_W +: BYTE_W] <= '0;
      else if (strobe.byteCap && strobe.byteSel == 2'(g))
        pc[g*BYTE_W +: BYTE_W] <= memRdData;
    end
  end

  // R4: start values
  always_ff @(posedge clk or negedge porN) begin
    if (!porN || strobe.initLoad) begin
      sp        <= SP_INIT;
      srIntMask <= '1;
      srMaxMode <= 1'b1;
      srBank    <= '0;
    end
  end

  // R5/R10: gear register
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                gearSel <= GEAR_INIT;
    else if (strobe.initLoad) gearSel <= GEAR_INIT;
    else if (strobe.gearWr)   gearSel <= gearReq;
  end

  // R6: ascending vector addresses
  assign memAddr = fetching ? VEC_BASE + ADDR_W'(strobe.byteSel) : '0;

endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_seq_pkg::*;
#(
  parameter int              ADDR_W    = 24,
  parameter int              BYTE_W    = 8,
  parameter int              MIN_LOW   = 10,
  parameter int              GEAR_W    = 3,
  parameter int              MASK_W    = 3,
  parameter int              BANK_W    = 3,
  parameter logic [ADDR_W-1:0] VEC_BASE  = 24'hFFFF00,
  parameter logic [ADDR_W-1:0] SP_INIT   = 24'h000100,
  parameter logic [GEAR_W-1:0] GEAR_INIT = 3'd4
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstInN,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [BYTE_W-1:0] memRdData,
  input  logic              memRdy,
  input  logic              gearWe,
  input  logic [GEAR_W-1:0] gearReq,
  output logic [GEAR_W-1:0] gearSel,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic [MASK_W-1:0] srIntMask,
  output logic              srMaxMode,
  output logic [BANK_W-1:0] srBank,
  output logic              periphRstN,
  output logic              aleOe,
  output logic              run
);

  localparam int VEC_BYTES = ADDR_W / BYTE_W;

  bootStrobe_t strobe;
  logic        fetching;

  boot_seq_ctrl #(
    .MIN_LOW  (MIN_LOW),
    .VEC_BYTES(VEC_BYTES)
  ) u_ctrl (
    .clk       (clk),
    .porN      (porN),
    .rstInN    (rstInN),
    .memRdy    (memRdy),
    .gearWe    (gearWe),
    .strobe    (strobe),
    .fetching  (fetching),
    .periphRstN(periphRstN),
    .aleOe     (aleOe),
    .run       (run)
  );

  boot_seq_dp #(
    .ADDR_W   (ADDR_W),
    .BYTE_W   (BYTE_W),
    .GEAR_W   (GEAR_W),
    .MASK_W   (MASK_W),
    .BANK_W   (BANK_W),
    .VEC_BASE (VEC_BASE),
    .SP_INIT  (SP_INIT),
    .GEAR_INIT(GEAR_INIT)
  ) u_dp (
    .clk      (clk),
    .porN     (porN),
    .strobe   (strobe),
    .fetching (fetching),
    .memRdData(memRdData),
    .gearReq  (gearReq),
    .memAddr  (memAddr),
    .pc       (pc),
    .sp       (sp),
    .srIntMask(srIntMask),
    .srMaxMode(srMaxMode),
    .srBank   (srBank),
    .gearSel  (gearSel)
  );

  assign memRdReq = fetching;

endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int              ADDR_W  = 24,
  parameter int              MIN_LOW = 10,
  parameter int              GEAR_W  = 3,
  parameter int              MASK_W  = 3,
  parameter int              BANK_W  = 3,
  parameter logic [ADDR_W-1:0] VEC_BASE = 24'hFFFF00,
  parameter logic [ADDR_W-1:0] SP_INIT  = 24'h000100
) (
  input logic              clk,
  input logic              porN,
  input logic              rstInN,
  input logic              memRdReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdy,
  input logic [GEAR_W-1:0] gearSel,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] sp,
  input logic [MASK_W-1:0] srIntMask,
  input logic              srMaxMode,
  input logic [BANK_W-1:0] srBank,
  input logic              periphRstN,
  input logic              aleOe,
  input logic              run
);

  localparam int CW = $clog2(MIN_LOW + 1);

  // independent tally of consecutive low samples on the pin
  logic [CW-1:0] seenLow;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                        seenLow <= '0;
    else if (rstInN)                  seenLow <= '0;
    else if (seenLow != CW'(MIN_LOW)) seenLow <= seenLow + 1'b1;
  end

  a_r1_full_low_time: assert property (@(posedge clk) disable iff (!porN)
    $fell(periphRstN) |-> seenLow == CW'(MIN_LOW));

  a_r3_quiet_in_reset: assert property (@(posedge clk) disable iff (!porN)
    !periphRstN |-> (!aleOe && !run && !memRdReq));

  a_r4_start_values: assert property (@(posedge clk) disable iff (!porN)
    $past(!periphRstN) |-> (sp == SP_INIT && srIntMask == '1 && srMaxMode && srBank == '0));

  a_r6_first_address: assert property (@(posedge clk) disable iff (!porN)
    $rose(memRdReq) |-> memAddr == VEC_BASE);

  a_r6_address_held: assert property (@(posedge clk) disable iff (!porN)
    (memRdReq && !memRdy) |=> (!memRdReq || $stable(memAddr)));

  a_r8_run_one_after: assert property (@(posedge clk) disable iff (!porN)
    $rose(run) |-> ($past(memRdReq, 2) && $past(memRdy, 2) && !$past(memRdReq)));

  a_r10_gear_locked: assert property (@(posedge clk) disable iff (!porN)
    !$stable(gearSel) |-> ($past(run) || $past(!periphRstN)));

  a_r11_pc_only_on_capture: assert property (@(posedge clk) disable iff (!porN)
    !$stable(pc) |-> ($past(memRdy) && $past(memRdReq)));

endmodule

bind boot_seq boot_seq_chk #(
  .ADDR_W  (ADDR_W),
  .MIN_LOW (MIN_LOW),
  .GEAR_W  (GEAR_W),
  .MASK_W  (MASK_W),
  .BANK_W  (BANK_W),
  .VEC_BASE(VEC_BASE),
  .SP_INIT (SP_INIT)
) u_chk (
  .clk       (clk),
  .porN      (porN),
  .rstInN    (rstInN),
  .memRdReq  (memRdReq),
  .memAddr   (memAddr),
  .memRdy    (memRdy),
  .gearSel   (gearSel),
  .pc        (pc),
  .sp        (sp),
  .srIntMask (srIntMask),
  .srMaxMode (srMaxMode),
  .srBank    (srBank),
  .periphRstN(periphRstN),
  .aleOe     (aleOe),
  .run       (run)
);

// File: tb/boot_seq_bench.sv
`timescale 1ns/1ps
module boot_seq_bench;

  localparam int          MIN_LOW = 10;
  localparam logic [23:0] BASE    = 24'hFFFF00;
  localparam logic [23:0] SPI     = 24'h000100;

  logic        clk = 1'b0, porN = 1'b0, rstInN = 1'b0;
  logic        memRdy = 1'b0, gearWe = 1'b0;
  logic [7:0]  memRdData = '0;
  logic [2:0]  gearReq = '0;
  logic        memRdReq, srMaxMode, periphRstN, aleOe, run;
  logic [23:0] memAddr, pc, sp;
  logic [2:0]  gearSel, srIntMask, srBank;

  boot_seq u_boot_seq (
    .clk(clk), .porN(porN), .rstInN(rstInN), .memRdReq(memRdReq), .memAddr(memAddr),
    .memRdData(memRdData), .memRdy(memRdy), .gearWe(gearWe), .gearReq(gearReq),
    .gearSel(gearSel), .pc(pc), .sp(sp), .srIntMask(srIntMask), .srMaxMode(srMaxMode),
    .srBank(srBank), .periphRstN(periphRstN), .aleOe(aleOe), .run(run)
  );

  always #2 clk = ~clk;

  int nChk = 0, nBad = 0;
  logic [7:0] vecTab [3];
  int lat = 1, wc = 0, lowsDriven = 0;
  bit collide = 1'b0;

  // behavioural reference: 0 reset, 1 reading, 2 gap, 3 running
  int mPhase = 0, mCnt = 0, mIdx = 0;
  logic [23:0] mPc = '0, mSp = SPI;
  logic [2:0]  mMask = 3'd7, mBank = '0, mGear = 3'd4;
  logic        mMax = 1'b1;
  bit          mHit;

  always @(posedge clk or negedge porN) begin
    if (!porN) begin
      mPhase = 0; mCnt = 0; mIdx = 0; mPc = '0; mSp = SPI;
      mMask = 3'd7; mMax = 1'b1; mBank = '0; mGear = 3'd4;
    end else begin
      mHit = !rstInN && (mCnt >= MIN_LOW - 1);
      if (mPhase == 0) begin
        mSp = SPI; mMask = 3'd7; mMax = 1'b1; mBank = '0; mGear = 3'd4;
      end
      if (mHit) mPhase = 0;
      else begin
        case (mPhase)
          0: if (rstInN) begin mPhase = 1; mIdx = 0; end
          1: if (memRdy) begin
               mPc[mIdx*8 +: 8] = memRdData;
               if (mIdx == 2) mPhase = 2; else mIdx++;
             end
          2: mPhase = 3;
          default: if (gearWe) mGear = gearReq;
        endcase
      end
      if (rstInN) mCnt = 0; else if (mCnt < MIN_LOW) mCnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R3 periphRstN", periphRstN, mPhase != 0);
    chk("R3 aleOe", aleOe, mPhase != 0);
    chk("R8 run", run, mPhase == 3);
    chk("R6 memRdReq", memRdReq, mPhase == 1);
    chk("R6 memAddr", memAddr, (mPhase == 1) ? BASE + mIdx : 0);
    chk("R7 pc", pc, mPc);
    chk("R4 sp", sp, mSp);
    chk("R4 status fields", {srIntMask, srMaxMode, srBank}, {mMask, mMax, mBank});
    chk("R5 gearSel", gearSel, mGear);
  endtask

  // inputs for the coming edge are set here, then the bench waits to the falling edge
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      if (!rstInN) lowsDriven++; else lowsDriven = 0;
      if (memRdReq !== 1'b1) begin memRdy = 1'b0; wc = 0; end
      else if (collide) begin
        memRdy = (lowsDriven == MIN_LOW);
        memRdData = vecTab[memAddr[1:0]];
      end
      else if (memRdy) begin memRdy = 1'b0; wc = 0; end
      else if (wc >= lat) begin memRdy = 1'b1; memRdData = vecTab[memAddr[1:0]]; end
      else wc++;
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic waitRun();
    for (int g = 0; g < 200 && !run; g++) tick(1);
  endtask

  initial begin
    #400us;
    nBad++; nChk++;
    $display("FAIL R8 watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", nChk - nBad, nChk);
    $finish;
  end

  initial begin
    vecTab[0] = 8'hA5; vecTab[1] = 8'h3C; vecTab[2] = 8'h12;
    tick(3);
    porN = 1'b1;
    tick(1);
    chk("R3 reset state periphRstN", periphRstN, 0);
    chk("R4 reset sp", sp, SPI);
    chk("R5 reset gear", gearSel, 3'd4);
    tick(5);

    rstInN = 1'b1; lat = 2;
    tick(1);
    chk("R6 first read address", memAddr, BASE);
    waitRun();
    chk("R7 pc assembled", pc, 24'h123CA5);
    chk("R8 run high", run, 1);

    gearReq = 3'd2; gearWe = 1'b1; tick(1); gearWe = 1'b0; tick(1);
    chk("R10 gear written while running", gearSel, 3'd2);

    rstInN = 1'b0; tick(9); rstInN = 1'b1; tick(2);
    chk("R2 nine-clock pulse ignored", run, 1);
    rstInN = 1'b0; tick(9); rstInN = 1'b1; tick(1); rstInN = 1'b0; tick(9); rstInN = 1'b1; tick(2);
    chk("R2 high sample restarts count", run, 1);
    chk("R2 gear untouched", gearSel, 3'd2);

    rstInN = 1'b0; tick(10);
    chk("R1 ten lows reset", periphRstN, 0);
    tick(1);
    chk("R5 gear forced", gearSel, 3'd4);
    chk("R11 pc kept through reset", pc, 24'h123CA5);
    gearReq = 3'd1; gearWe = 1'b1; tick(3); gearWe = 1'b0;
    chk("R10 gear write ignored in reset", gearSel, 3'd4);

    // R9: qualification lands on the same edge as the second byte's ready
    vecTab[0] = 8'h77; vecTab[1] = 8'h88; vecTab[2] = 8'h99;
    rstInN = 1'b1; lat = 1;
    for (int g = 0; g < 100 && !(memRdReq === 1'b1 && memAddr == BASE + 1); g++) tick(1);
    rstInN = 1'b0; collide = 1'b1; tick(12); collide = 1'b0;
    chk("R9 colliding byte not stored", pc, 24'h123C77);
    chk("R9 aborted to reset", periphRstN, 0);

    rstInN = 1'b1; lat = 0;
    waitRun();
    chk("R7 second vector", pc, 24'h998877);

    // R10: gear write held across qualification
    gearReq = 3'd1; gearWe = 1'b1; rstInN = 1'b0; tick(12); gearWe = 1'b0;
    chk("R10 reset beats gear write", gearSel, 3'd4);
    rstInN = 1'b1;
    waitRun();
    chk("R8 run after final fetch", run, 1);

    $display("%0d/%0d checks passed", nChk - nBad, nChk);
    $finish;
  end

endmodule